// File: doc/BRIEF.md
# Clock Multiplier Control Sequencer

This block holds the one-byte control and status register of a 4x clock multiplier, the kind that lifts a 12 MHz reference to the 48 MHz needed by full-speed USB. Software reaches the register over a small byte bus with an address, a write strobe, write data and combinational read data. The block drives the multiplier's enable, initialize and input-select lines and takes a lock indication back from it. That indication passes through a two-flop synchronizer before it becomes the ready flag.

The block enforces the multiplier's bring-up order. Software first clears the register and picks the source, then sets enable. It waits out a settle window of `SETTLE_CYCLES` reference cycles, then adds initialize and polls ready. An initialize request that comes too early is dropped, and a sticky error output records it. An auto-start mode can run the same order in hardware when it sees a pulse on `start`. If lock does not arrive within `LOCK_TIMEOUT` cycles of the initialize step, that mode parks in a timeout state.

Top module: `clkmul_seq`

## Requirements
- R1: After reset the register reads 0x00, `mul_en`, `mul_init`, `mul_src` and `seq_err` are 0, and `auto_state` is 0 (idle).
- R2: In the register at address `REG_ADDR`, bit 7 is enable and drives `mul_en`, bit 6 is initialize and drives `mul_init`, bit 5 is the ready flag, and bit 0 picks the source on `mul_src` (0 internal oscillator, 1 external clock). A read at any other address returns 0x00.
- R3: Bits 4..1 always read 0. Writes to bits 4..1 and to bit 5 change nothing.
- R4: If a write sets bit 6 while enable is currently 0, the initialize request is ignored and `seq_err` is set. The enable bit of that same write still takes effect.
- R5: If bit 6 is written before `SETTLE_CYCLES` cycles have passed since enable was set, the request is ignored and `seq_err` is set.
- R6: A write of 0xC0 (with the chosen source in bit 0) after the settle window sets `mul_init`.
- R7: Ready reads 1 only while enable and an accepted initialize are both held and the synchronized lock is high. It follows `lock_in` with two cycles of delay, so it reads 0 again after lock drops.
- R8: Writing enable to 0 clears enable, initialize and ready by the next cycle, even while `lock_in` stays high.
- R9: Changing bit 0 while enabled clears initialize and ready and restarts the settle window.
- R10: `seq_err` stays set until a register write that has bits 7 and 6 both 0.
- R11: A `start` pulse in idle, done or timeout makes `auto_state` step through 1 (enable), 2 (settle), 3 (init), 4 (wait lock) and 5 (done), in that order. The sequence ends with ready reading 1.
- R12: Without lock, the wait-lock state moves to 6 (timeout) after `LOCK_TIMEOUT` cycles. A later `start` runs the sequence again.
- R13: While `auto_state` is 1 to 4, bus writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| start | input | 1 | Auto-start pulse |
| lock_in | input | 1 | Asynchronous lock indication from the multiplier |
| mul_en | output | 1 | Multiplier enable |
| mul_init | output | 1 | Multiplier initialize |
| mul_src | output | 1 | Input select, 1 = external clock |
| seq_err | output | 1 | Sticky sequence-error flag |
| auto_state | output | 3 | Auto-start state code |

## Verification
The assertions assume that `start` and the bus signals are synchronous to `clk`. They also assume that `lock_in` may toggle at any time, because only its synchronized copy is used. The bench changes every input half a cycle away from the rising edge. It models lock by raising `lock_in` only after it sees `mul_init` high, and it drops lock on purpose when it tests ready loss and timeout. During auto-start runs it writes to the bus only to show that those writes are ignored.

// File: rtl/clkmul_seq.sv
module clkmul_seq #(
  parameter int ADDR_W        = 4,
  parameter int REG_ADDR      = 0,
  parameter int SETTLE_CYCLES = 64,
  parameter int LOCK_TIMEOUT  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              start,
  input  logic              lock_in,
  output logic              mul_en,
  output logic              mul_init,
  output logic              mul_src,
  output logic              seq_err,
  output logic [2:0]        auto_state
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int TW = $clog2(LOCK_TIMEOUT + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ENABLE, S_SETTLE, S_INIT, S_WAIT, S_DONE, S_TIMEOUT
  } st_t;

  st_t st;
  logic en_q, init_q, src_q, err_q, lock_s1, lock_s2;
  logic [SW-1:0] settle_cnt;
  logic [TW-1:0] wait_cnt;

  logic busy, hit, wr, settled, rdy, src_flip, init_ok, init_bad, err_clr;

  assign busy     = (st == S_ENABLE) || (st == S_SETTLE) || (st == S_INIT) || (st == S_WAIT);
  assign hit      = bus_addr == ADDR_W'(REG_ADDR);
  assign wr       = bus_we && hit && !busy;
  assign settled  = settle_cnt == SW'(SETTLE_CYCLES);
  assign rdy      = en_q && init_q && lock_s2;
  assign src_flip = wr && en_q && (bus_wdata[0] != src_q);
  assign init_ok  = bus_wdata[6] && bus_wdata[7] && en_q && settled && !src_flip;
  assign init_bad = wr && bus_wdata[6] && !init_ok;
  assign err_clr  = wr && !bus_wdata[7] && !bus_wdata[6];

  assign bus_rdata  = hit ? {en_q, init_q, rdy, 4'b0000, src_q} : 8'h00;
  assign mul_en     = en_q;
  assign mul_init   = init_q;
  assign mul_src    = src_q;
  assign seq_err    = err_q;
  assign auto_state = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_s1 <= 1'b0;
      lock_s2 <= 1'b0;
    end else begin
      lock_s1 <= lock_in;
      lock_s2 <= lock_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_q || src_flip) settle_cnt <= '0;
    else if (!settled)               settle_cnt <= settle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (init_bad) err_q <= 1'b1;
    else if (err_clr)  err_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      init_q   <= 1'b0;
      src_q    <= 1'b0;
      st       <= S_IDLE;
      wait_cnt <= '0;
    end else begin
      if (wr) begin
        en_q   <= bus_wdata[7];
        src_q  <= bus_wdata[0];
        init_q <= wr && init_ok;
      end
      case (st)
        S_IDLE, S_DONE, S_TIMEOUT:
          if (start) begin
            en_q   <= 1'b0;
            init_q <= 1'b0;
            st     <= S_ENABLE;
          end
        S_ENABLE: begin
          en_q <= 1'b1;
          st   <= S_SETTLE;
        end
        S_SETTLE:
          if (settled) st <= S_INIT;
        S_INIT: begin
          init_q   <= 1'b1;
          wait_cnt <= '0;
          st       <= S_WAIT;
        end
        S_WAIT:
          if (rdy) st <= S_DONE;
          else if (wait_cnt == TW'(LOCK_TIMEOUT - 1)) st <= S_TIMEOUT;
          else wait_cnt <= wait_cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkmul_seq_chk.sv
module clkmul_seq_chk #(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              mul_en,
  input logic              mul_init,
  input logic              seq_err,
  input logic [2:0]        auto_state
);
  logic st_busy;
  assign st_busy = (auto_state >= 3'd1) && (auto_state <= 3'd4);

  p_init_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mul_init |-> mul_en);
  p_en_rise_no_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mul_en) |-> !mul_init);
  p_init_after_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mul_init) |-> $past(mul_en));
  p_ready_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[5] |-> (mul_en && mul_init));
  p_en_drop_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mul_en) |-> !bus_rdata[5]);
  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[4:1] == 4'b0000);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && !(bus_we && !st_busy && bus_addr == ADDR_W'(REG_ADDR) && bus_wdata[7:6] == 2'b00))
      |=> seq_err);
  p_state_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    auto_state <= 3'd6);
  p_done_from_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_state == 3'd5 && $past(auto_state) != 3'd5) |-> $past(auto_state) == 3'd4);
  p_busy_hold_en_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_state == 3'd2 && $past(auto_state) == 3'd2) |-> mul_en);
endmodule

bind clkmul_seq clkmul_seq_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mul_en(mul_en),
  .mul_init(mul_init), .seq_err(seq_err), .auto_state(auto_state)
);

// File: tb/clkmul_seq_tb.sv
module clkmul_seq_tb;
  localparam int ADDR_W = 4;
  localparam int TOUT   = 1024;

  logic clk = 0, rst_n = 0, bus_we = 0, start = 0, lock_in = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic mul_en, mul_init, mul_src, seq_err;
  logic [2:0] auto_state;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  clkmul_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start(start),
    .lock_in(lock_in), .mul_en(mul_en), .mul_init(mul_init), .mul_src(mul_src),
    .seq_err(seq_err), .auto_state(auto_state)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); bus_addr = '0; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata; bus_addr = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd('0, d);
    chk("R1 reg", d, 8'h00);
    chk("R1 outs", {4'b0, mul_en, mul_init, mul_src, seq_err}, 8'h00);
    chk("R1 state", {5'b0, auto_state}, 8'h00);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    wr(8'h3E);
    rd('0, d);
    chk("R3 unused bits", d, 8'h00);
    chk("R3 no err", {7'b0, seq_err}, 8'h00);
    wr(8'h01);
    chk("R2 src external", {7'b0, mul_src}, 8'h01);
    wr(8'h00);
  endtask

  task automatic t_init_no_en();
    logic [7:0] d;
    wr(8'hC0);
    rd('0, d);
    chk("R4 init dropped, en kept", d, 8'h80);
    chk("R4 err", {7'b0, seq_err}, 8'h01);
    wr(8'h00);
    chk("R10 err cleared", {7'b0, seq_err}, 8'h00);
  endtask

  task automatic t_early_init();
    logic [7:0] d;
    wr(8'h80);
    idle(5);
    wr(8'hC0);
    rd('0, d);
    chk("R5 early init ignored", d, 8'h80);
    chk("R5 err", {7'b0, seq_err}, 8'h01);
    wr(8'h80);
    chk("R10 err sticky", {7'b0, seq_err}, 8'h01);
    wr(8'h00);
  endtask

  task automatic t_normal();
    logic [7:0] d;
    wr(8'h80);
    idle(70);
    wr(8'hC0);
    chk("R6 init out", {7'b0, mul_init}, 8'h01);
    chk("R2 en out", {7'b0, mul_en}, 8'h01);
    rd('0, d);
    chk("R7 not ready yet", d, 8'hC0);
    lock_in = 1;
    @(negedge clk);
    rd('0, d);
    chk("R7 ready", d, 8'hE0);
    rd(4'd3, d);
    chk("R2 other addr", d, 8'h00);
    wr(8'hDE);
    rd('0, d);
    chk("R3 writes to 5..1 ignored", d, 8'hE0);
    lock_in = 0;
    idle(3);
    rd('0, d);
    chk("R7 lock lost", d, 8'hC0);
    lock_in = 1;
    idle(3);
    wr(8'h00);
    rd('0, d);
    chk("R8 cleared", d, 8'h00);
    chk("R8 init out", {7'b0, mul_init}, 8'h00);
  endtask

  task automatic t_src_change();
    logic [7:0] d;
    wr(8'h80);
    idle(70);
    wr(8'hC0);
    idle(3);
    wr(8'h81);
    rd('0, d);
    chk("R9 src change drops init/ready", d, 8'h81);
    wr(8'hC1);
    chk("R9 settle restarted", {6'b0, mul_init, seq_err}, 8'h01);
    wr(8'h00);
    lock_in = 0;
  endtask

  task automatic t_auto(input bit give_lock, input logic [2:0] final_st, input string req);
    logic [2:0] prev = auto_state;
    int seen_bad = 0;
    logic [7:0] d;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    prev = 3'd0;
    for (int i = 0; i < TOUT + 300; i++) begin
      if (auto_state != prev) begin
        if (!(auto_state == prev + 3'd1 || (prev == 3'd4 && auto_state == 3'd6))) seen_bad++;
        prev = auto_state;
      end
      if (auto_state == 3'd2 && i == 10) begin
        wr(8'h00);
        chk("R13 write ignored while busy", {7'b0, mul_en}, 8'h01);
      end
      if (give_lock && mul_init) lock_in = 1;
      if (auto_state == 3'd5 || auto_state == 3'd6) break;
      @(negedge clk);
    end
    chk({req, " order"}, seen_bad[7:0], 8'h00);
    chk({req, " final"}, {5'b0, auto_state}, {5'b0, final_st});
    if (give_lock) begin
      rd('0, d);
      chk("R11 ready", d, 8'hE0);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    t_reset();
    t_unused();
    t_init_no_en();
    t_early_init();
    t_normal();
    t_src_change();
    t_auto(0, 3'd6, "R12 timeout");
    t_auto(1, 3'd5, "R11 auto");
    lock_in = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule